// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide flash bus and turns one request (program a byte, erase a sector, erase the whole array) into the write cycles that the device needs to unlock the operation. It then reads the target location until the operation has finished. The caller supplies an operation code, a target address and a data byte, and pulses `start`. The sequencer reports the outcome with a one-cycle `done` pulse, and raises `err` in the same cycle if the operation failed.

The bus side is kept abstract. There is one write request and one read request, and both are completed by a shared acknowledge. Completion can be detected in two ways, chosen per request. In the first, bit 7 of the read data carries the complement of the expected bit until the operation ends. In the second, bit 6 alternates on every read while the device is busy. The device finishes asynchronously to the host, so a single poll can catch it in mid-change. Every poll that looks wrong is therefore followed by two confirming reads. Polling is bounded by a timeout, with a separate limit for each operation type. The caller must erase the target sector before programming it; the sequencer does not check this.

Top module: `flash_pe_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request given, `busy`, `done`, `err`, `bw_req` and `br_req` are all low.
- R2: Operation code 2'b01 (program) issues exactly four writes, as address/data pairs in this order: 555h/AAh, 2AAh/55h, 555h/A0h, and finally the target address with the caller's data byte.
- R3: Code 2'b10 (sector erase) and code 2'b11 (chip erase) each issue exactly six writes. Both begin 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h. The sixth write is 555h/10h for chip erase, or the target address with 20h for sector erase.
- R4: The first write request is visible in the cycle after `start` is accepted. A request holds its address and data until `b_ack`, each acknowledge completes exactly one transfer, and write and read requests are never raised together.
- R5: In bit-7 mode (`poll_mode`=0) every read goes to the target address. A read whose bit 7 equals the expected bit (the data's bit 7 for a program, 1 for an erase) completes the operation.
- R6: In bit-6 mode (`poll_mode`=1) the operation is complete when two consecutive poll reads return the same bit 6. The first read after issue, or after a failed recheck, only records bit 6.
- R7: A poll that does not show completion is followed by exactly two more reads of the target. If both return the full expected byte (the data for a program, FFh for an erase), the operation is done. Otherwise polling starts over.
- R8: Poll time is counted in cycles from the end of the last write, with separate limits for program, sector erase and chip erase. When a pair of rechecks fails after the limit has been reached, the operation ends with `err`.
- R9: `done` is high for exactly one cycle per accepted request. `err` is high only together with `done`, and only for a failed or rejected request.
- R10: A `start` while `busy` is high is ignored, and the running operation's bus cycles are unchanged.
- R11: A request with operation code 2'b00 is rejected: `done` and `err` pulse in the next cycle and no bus cycle takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| op | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 invalid |
| addr | input | AW | Target byte address or sector address |
| wdata | input | 8 | Byte to program |
| poll_mode | input | 1 | 0 bit-7 complement polling, 1 bit-6 alternation polling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| bw_req | output | 1 | Bus write request |
| br_req | output | 1 | Bus read request |
| b_addr | output | AW | Bus address |
| b_wdata | output | 8 | Bus write data |
| b_ack | input | 1 | Bus transfer acknowledge |
| b_rdata | input | 8 | Bus read data, valid with b_ack |

## Verification
The bench builds the block with AW=19 and timeout limits of 60, 80 and 100 cycles. These limits are short enough that a device which never finishes reaches the timeout error within a few dozen reads, while normal runs with up to four busy reads finish well inside them. A behavioural bus model in the bench can be set to return a chosen number of busy reads before the valid byte. This makes each path deterministic: immediate success, success through the two rechecks, a failed recheck followed by a new poll, and the case where the poll read agrees on bit 6 by chance.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } fseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_POLL,
    ST_CHK1,
    ST_CHK2
  } fseq_st_e;

  localparam logic [11:0] UNLK_A1  = 12'h555;
  localparam logic [11:0] UNLK_A2  = 12'h2AA;
  localparam logic [7:0]  KEY_1    = 8'hAA;
  localparam logic [7:0]  KEY_2    = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_ERS  = 8'h80;
  localparam logic [7:0]  CMD_CHIP = 8'h10;
  localparam logic [7:0]  CMD_SECT = 8'h20;
  localparam logic [7:0]  ERASED   = 8'hFF;

  function automatic logic [2:0] last_step(fseq_op_e o);
    return (o == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

endpackage

// File: rtl/fseq_cmd_table.sv
module fseq_cmd_table
  import fseq_pkg::*;
#(
  parameter int AW = 19
) (
  input  fseq_op_e        op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [7:0]      tgt_data,
  output logic [AW-1:0]   cyc_addr,
  output logic [7:0]      cyc_data,
  output logic            is_last
);
  localparam int PADW = AW - 12;
  localparam logic [AW-1:0] A1 = {{PADW{1'b0}}, UNLK_A1};
  localparam logic [AW-1:0] A2 = {{PADW{1'b0}}, UNLK_A2};

  always_comb begin
    cyc_addr = A1;
    cyc_data = KEY_1;
    case (step)
      3'd0: begin cyc_addr = A1; cyc_data = KEY_1; end
      3'd1: begin cyc_addr = A2; cyc_data = KEY_2; end
      3'd2: begin cyc_addr = A1; cyc_data = (op == OP_PROG) ? CMD_PROG : CMD_ERS; end
      3'd3: begin
        if (op == OP_PROG) begin
          cyc_addr = tgt_addr;
          cyc_data = tgt_data;
        end else begin
          cyc_addr = A1;
          cyc_data = KEY_1;
        end
      end
      3'd4: begin cyc_addr = A2; cyc_data = KEY_2; end
      3'd5: begin
        if (op == OP_CHIP) begin
          cyc_addr = A1;
          cyc_data = CMD_CHIP;
        end else begin
          cyc_addr = tgt_addr;
          cyc_data = CMD_SECT;
        end
      end
      default: begin cyc_addr = A1; cyc_data = KEY_1; end
    endcase
    is_last = (step == last_step(op));
  end

  // R2 / R3: the step index never runs past the final write of the operation
  always_comb begin
    if (op != OP_NONE)
      a_r3_step_range: assert (step <= last_step(op) || $isunknown(step))
        else $error("step beyond last write");
  end

endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval (
  input  logic       mode_tog,
  input  logic [7:0] rd_data,
  input  logic [7:0] exp_data,
  input  logic       have_prev,
  input  logic       prev_b6,
  output logic       first_tog,
  output logic       poll_hit,
  output logic       full_ok
);
  always_comb begin
    first_tog = mode_tog && !have_prev;
    if (mode_tog)
      poll_hit = have_prev && (rd_data[6] == prev_b6);
    else
      poll_hit = (rd_data[7] == exp_data[7]);
    full_ok = (rd_data == exp_data);
  end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (en && (cnt_q < limit));
    cnt_n  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign expired = (cnt_q >= limit);

  // R8: while polling, the count saturates at the selected limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (cnt_q <= limit));

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fseq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int TMO_PROG = 2000,
  parameter int TMO_SECT = 100000,
  parameter int TMO_CHIP = 400000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          poll_mode,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          bw_req,
  output logic          br_req,
  output logic [AW-1:0] b_addr,
  output logic [7:0]    b_wdata,
  input  logic          b_ack,
  input  logic [7:0]    b_rdata
);
  localparam int TMO_MAX = (TMO_PROG > TMO_SECT) ?
                           ((TMO_PROG > TMO_CHIP) ? TMO_PROG : TMO_CHIP) :
                           ((TMO_SECT > TMO_CHIP) ? TMO_SECT : TMO_CHIP);
  localparam int CW = $clog2(TMO_MAX + 1);

  fseq_st_e      st_q, st_n;
  logic [2:0]    step_q, step_n;
  fseq_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          mode_q;
  logic          prev_q, prev_n;
  logic          hprev_q, hprev_n;
  logic          chk_q, chk_n;
  logic          done_q, done_n, err_q, err_n;
  logic          req_ld;

  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data;
  logic          cyc_last;
  logic [7:0]    exp_data;
  logic          first_tog, poll_hit, full_ok;
  logic [CW-1:0] tmo_lim;
  logic          tmo_exp;
  logic          polling;

  assign exp_data = (op_q == OP_PROG) ? data_q : ERASED;
  assign polling  = (st_q == ST_POLL) || (st_q == ST_CHK1) || (st_q == ST_CHK2);

  always_comb begin
    case (op_q)
      OP_PROG: tmo_lim = CW'(TMO_PROG);
      OP_SECT: tmo_lim = CW'(TMO_SECT);
      default: tmo_lim = CW'(TMO_CHIP);
    endcase
  end

  fseq_cmd_table #(.AW(AW)) i_tbl (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data),
    .is_last  (cyc_last)
  );

  fseq_poll_eval i_eval (
    .mode_tog  (mode_q),
    .rd_data   (b_rdata),
    .exp_data  (exp_data),
    .have_prev (hprev_q),
    .prev_b6   (prev_q),
    .first_tog (first_tog),
    .poll_hit  (poll_hit),
    .full_ok   (full_ok)
  );

  fseq_timer #(.CW(CW)) i_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q == ST_ISSUE),
    .en      (polling),
    .limit   (tmo_lim),
    .expired (tmo_exp)
  );

  // next state
  always_comb begin
    st_n    = st_q;
    step_n  = step_q;
    prev_n  = prev_q;
    hprev_n = hprev_q;
    chk_n   = chk_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    req_ld  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (fseq_op_e'(op) == OP_NONE) begin
            done_n = 1'b1;
            err_n  = 1'b1;
          end else begin
            req_ld = 1'b1;
            step_n = 3'd0;
            st_n   = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (b_ack) begin
          if (cyc_last) begin
            hprev_n = 1'b0;
            st_n    = ST_POLL;
          end else begin
            step_n = step_q + 3'd1;
          end
        end
      end
      ST_POLL: begin
        if (b_ack) begin
          if (first_tog) begin
            hprev_n = 1'b1;
            prev_n  = b_rdata[6];
          end else if (poll_hit) begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end else begin
            prev_n = b_rdata[6];
            st_n   = ST_CHK1;
          end
        end
      end
      ST_CHK1: begin
        if (b_ack) begin
          chk_n = full_ok;
          st_n  = ST_CHK2;
        end
      end
      ST_CHK2: begin
        if (b_ack) begin
          if (chk_q && full_ok) begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end else if (tmo_exp) begin
            done_n = 1'b1;
            err_n  = 1'b1;
            st_n   = ST_IDLE;
          end else begin
            hprev_n = 1'b0;
            st_n    = ST_POLL;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      prev_q  <= 1'b0;
      hprev_q <= 1'b0;
      chk_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      step_q  <= step_n;
      prev_q  <= prev_n;
      hprev_q <= hprev_n;
      chk_q   <= chk_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else if (req_ld) begin
      op_q   <= fseq_op_e'(op);
      addr_q <= addr;
      data_q <= wdata;
      mode_q <= poll_mode;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign bw_req  = (st_q == ST_ISSUE);
  assign br_req  = polling;
  assign b_addr  = (st_q == ST_ISSUE) ? cyc_addr : addr_q;
  assign b_wdata = cyc_data;

  // R4: a pending request keeps its address and data until acknowledged
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((bw_req || br_req) && !b_ack) |=> ($stable(b_addr) && $stable(b_wdata) &&
                                        $stable(bw_req) && $stable(br_req)));

  // R4: write and read requests are exclusive
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bw_req && br_req));

  // R5: every poll read addresses the captured target
  a_r5_rd_target: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |-> (b_addr == addr_q));

  // R9: done lasts a single cycle and err only accompanies done
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10: a start during an operation does not restart the write sequence
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && bw_req && !b_ack) |=> $stable(step_q));

endmodule

// File: tb/test_flash_pe_seq.sv
module test_flash_pe_seq;
  localparam int AW = 19;

  logic          clk, rst_n;
  logic          start, poll_mode;
  logic [1:0]    op;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic          busy, done, err, bw_req, br_req, b_ack;
  logic [AW-1:0] b_addr;
  logic [7:0]    b_wdata, b_rdata;

  int n_chk = 0;
  int n_bad = 0;

  flash_pe_seq #(.AW(AW), .TMO_PROG(60), .TMO_SECT(80), .TMO_CHIP(100)) i_flash_pe_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .poll_mode(poll_mode), .busy(busy), .done(done), .err(err),
    .bw_req(bw_req), .br_req(br_req), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_ack(b_ack), .b_rdata(b_rdata)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  // behavioural bus / device model
  logic          m_clr;
  int            cfg_len, cfg_busy, cfg_lat;
  logic [7:0]    cfg_valid;
  logic          cfg_b7;
  logic [AW-1:0] cfg_tgt;
  int            m_wc, m_rc, m_bad_addr, m_cnt, m_busy_left;
  logic          m_t;
  logic [AW-1:0] m_wa [8];
  logic [7:0]    m_wd [8];

  always @(posedge clk) begin
    b_ack <= 1'b0;
    if (m_clr) begin
      m_wc <= 0; m_rc <= 0; m_bad_addr <= 0; m_cnt <= 0; m_busy_left <= 0; m_t <= 1'b0;
    end else if ((bw_req || br_req) && !b_ack) begin
      if (m_cnt < cfg_lat) m_cnt <= m_cnt + 1;
      else begin
        m_cnt <= 0;
        b_ack <= 1'b1;
        if (bw_req) begin
          if (m_wc < 8) begin
            m_wa[m_wc[2:0]] <= b_addr;
            m_wd[m_wc[2:0]] <= b_wdata;
          end
          m_wc <= m_wc + 1;
          if (m_wc + 1 == cfg_len) begin
            m_busy_left <= cfg_busy;
            m_t <= 1'b0;
          end
        end else begin
          m_rc <= m_rc + 1;
          if (b_addr != cfg_tgt) m_bad_addr <= m_bad_addr + 1;
          if (m_busy_left > 0) begin
            b_rdata <= {cfg_b7, m_t, 6'h00};
            m_t <= ~m_t;
            m_busy_left <= m_busy_left - 1;
          end else begin
            b_rdata <= cfg_valid;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_wa(input logic [1:0] o, input int k, input logic [AW-1:0] a);
    case (k)
      0, 2: return AW'(12'h555);
      1, 4: return AW'(12'h2AA);
      3:    return (o == 2'b01) ? a : AW'(12'h555);
      default: return (o == 2'b11) ? AW'(12'h555) : a;
    endcase
  endfunction

  function automatic logic [7:0] exp_wd(input logic [1:0] o, input int k, input logic [7:0] d);
    case (k)
      0, 3: return (k == 3 && o == 2'b01) ? d : 8'hAA;
      1, 4: return 8'h55;
      2:    return (o == 2'b01) ? 8'hA0 : 8'h80;
      default: return (o == 2'b11) ? 8'h10 : 8'h20;
    endcase
  endfunction

  // one request; exp_reads < 0 skips the read count check; poke issues a second start while busy
  task automatic run_op(input logic [1:0] o, input logic md, input logic [AW-1:0] a,
                        input logic [7:0] d, input int bsy, input int lat,
                        input int exp_reads, input bit exp_err, input bit poke);
    int  cyc;
    bit  seen, err_seen;
    cfg_len   = (o == 2'b01) ? 4 : 6;
    cfg_busy  = bsy;
    cfg_lat   = lat;
    cfg_valid = (o == 2'b01) ? d : 8'hFF;
    cfg_b7    = (o == 2'b01) ? ~d[7] : 1'b0;
    cfg_tgt   = a;
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
    start = 1'b1; op = o; poll_mode = md; addr = a; wdata = d;
    seen = 0; err_seen = 0; cyc = 0;
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        // R4: first write request one cycle after acceptance
        check(bw_req && b_addr == AW'(12'h555) && b_wdata == 8'hAA, "R4 first write timing",
              {bw_req, b_wdata}, {1'b1, 8'hAA});
        check(busy, "R4 busy after start", busy, 1);
      end
      start = 1'b0;
      if (poke && cyc == 3) begin start = 1'b1; op = 2'b11; addr = '0; end
      if (poke && cyc == 3) check(busy, "R10 busy at second start", busy, 1);
      if (done) begin seen = 1; err_seen = err; end
    end
    start = 1'b0;
    check(seen, "R9 done observed", seen, 1);
    check(err_seen == exp_err, "R8 R9 err flag", err_seen, exp_err);
    check(m_wc == cfg_len, (o == 2'b01) ? "R2 write count" : "R3 write count", m_wc, cfg_len);
    for (int k = 0; k < cfg_len && k < 8; k++) begin
      check(m_wa[k] == exp_wa(o, k, a) && m_wd[k] == exp_wd(o, k, d),
            (o == 2'b01) ? "R2 write sequence" : "R3 write sequence",
            {m_wa[k], m_wd[k]}, {exp_wa(o, k, a), exp_wd(o, k, d)});
    end
    if (exp_reads >= 0)
      check(m_rc == exp_reads, md ? "R6 R7 read count" : "R5 R7 read count", m_rc, exp_reads);
    check(m_bad_addr == 0, "R5 reads at target", m_bad_addr, 0);
    @(negedge clk);
    check(!done && !err && !busy, "R9 single-cycle done", {done, err, busy}, 0);
  endtask

  typedef struct packed {
    logic [1:0]    o;
    logic          md;
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic [11:0]   bsy;
    logic [1:0]    lat;
    logic [7:0]    reads;
  } vec_t;

  // busy = busy reads the model returns; reads = expected total reads from R5..R7
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 19'h12345, 8'h3C, 12'd0, 2'd0, 8'd1},  // R5 immediate
    '{2'b01, 1'b0, 19'h00777, 8'h81, 12'd1, 2'd1, 8'd3},  // R7 rechecks pass
    '{2'b10, 1'b0, 19'h40080, 8'h00, 12'd2, 2'd0, 8'd4},  // R7 recheck fails, repoll
    '{2'b11, 1'b0, 19'h00100, 8'h00, 12'd4, 2'd2, 8'd6},  // R5 R7 two rounds
    '{2'b01, 1'b1, 19'h7FFFF, 8'h5A, 12'd0, 2'd0, 8'd2},  // R6 stable pair
    '{2'b01, 1'b1, 19'h00ABC, 8'h3C, 12'd1, 2'd0, 8'd2},  // R6 chance agreement on bit 6
    '{2'b10, 1'b1, 19'h05500, 8'h00, 12'd2, 2'd1, 8'd4},  // R6 R7 toggle then rechecks
    '{2'b11, 1'b1, 19'h00000, 8'h00, 12'd3, 2'd0, 8'd6},  // R6 R7 failed recheck, new pair
    '{2'b01, 1'b1, 19'h2AAAA, 8'h5A, 12'd1, 2'd3, 8'd4}   // R6 R7 mismatch then confirm
  };

  initial begin
    #(5ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_clr = 1'b1; start = 1'b0; op = 2'b00; poll_mode = 1'b0; addr = '0; wdata = '0;
    cfg_len = 4; cfg_busy = 0; cfg_lat = 0; cfg_valid = '0; cfg_b7 = 1'b0; cfg_tgt = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({busy, done, err, bw_req, br_req} == 5'b0, "R1 outputs in reset",
          {busy, done, err, bw_req, br_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, err, bw_req, br_req} == 5'b0, "R1 idle after reset",
          {busy, done, err, bw_req, br_req}, 0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].o, VECS[i].md, VECS[i].a, VECS[i].d, int'(VECS[i].bsy),
             int'(VECS[i].lat), int'(VECS[i].reads), 1'b0, 1'b0);

    // R10: second start while busy has no effect on the running program
    run_op(2'b01, 1'b0, 19'h01234, 8'hC3, 2, 0, 4, 1'b0, 1'b1);

    // R8: device never finishes, program limit reached
    run_op(2'b01, 1'b0, 19'h00042, 8'h11, 4000, 0, -1, 1'b1, 1'b0);
    // R8: same for a sector erase in bit-6 mode
    run_op(2'b10, 1'b1, 19'h00200, 8'h00, 4000, 1, -1, 1'b1, 1'b0);
    // recovery after timeout
    run_op(2'b11, 1'b0, 19'h00000, 8'h00, 0, 0, 1, 1'b0, 1'b0);

    // R11: invalid opcode rejected without bus activity
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
    start = 1'b1; op = 2'b00;
    @(negedge clk);
    start = 1'b0;
    check(done && err, "R11 reject pulse", {done, err}, 2'b11);
    check(!bw_req && !br_req && !busy, "R11 no bus cycle", {bw_req, br_req, busy}, 0);
    repeat (3) @(negedge clk);
    check(m_wc == 0 && m_rc == 0, "R11 bus untouched", m_wc + m_rc, 0);
    check(!done && !err, "R9 reject pulse ends", {done, err}, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule